// File: doc/BRIEF.md
# Banked Multi-Lane Register File

This block stores the 128 architectural registers of a four-lane vector datapath. Each register is 64 bits wide and is named by a 7-bit number. Registers 1 to 31 are kept in a small flip-flop array. That array serves every lane in the same cycle, for both reads and writes, so scalar code never waits. Register 0 is hard-wired to zero.

Registers 32 to 127 are spread over eight single-read, single-write memory banks. The bank is picked by the three low bits of the register number, and the remaining four bits give the row inside the bank. When two lanes need the same port of one bank in the same cycle, the block serves them one per cycle in lane order and raises `stall_o`. While stall is high the issuing stage holds all of its requests unchanged. The block remembers which lanes have already been served, so each lane is served exactly once. Each bank has an enable output that is high only in cycles when that bank is accessed, so an idle bank can have its clock gated.

Top module: `banked_rf`

## Requirements
- R1: Reads and writes of registers below 32 never cause a stall, even when all four lanes read and all four lanes write that region in the same cycle.
- R2: Register 0 always reads as zero, and a write to register 0 has no effect.
- R3: A register numbered 32 or above lives in bank `addr[2:0]`. Four accesses that fall in four different banks complete in one cycle with no stall.
- R4: When several lanes read the same bank in one cycle, the lowest-numbered pending lane is served first. `stall_o` stays high until the last of them is served, one lane per cycle in ascending lane order. The requester holds its inputs stable while `stall_o` is high.
- R5: Writes from several lanes to one bank are serialized in the same ascending lane order. When two lanes write the same banked register, the higher lane's data is what remains.
- R6: In one cycle, a read and a write that hit the same bank are both served with no stall.
- R7: Read data and `rd_valid_o[l]` appear in the cycle after the lane's read is served. `rd_valid_o[l]` is never high without a read request from that lane in the previous cycle.
- R8: If several lanes write the same register below 32 in one cycle, the highest-numbered lane's data is stored.
- R9: A read of a register that is written in the same cycle returns the value held before that write. There is no bypass.
- R10: `bank_en_o[b]` is high in a cycle if and only if a read or a write to bank b is served in that cycle. With no requests, all enables are low.
- R11: After reset, registers 1 to 31 read as zero, and `stall_o`, `rd_valid_o` and `bank_en_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd_req_i | input | LANES | Read request per lane |
| rd_addr_i | input | LANES x 7 | Register number read by each lane |
| wr_req_i | input | LANES | Write request per lane |
| wr_addr_i | input | LANES x 7 | Register number written by each lane |
| wr_data_i | input | LANES x 64 | Write data per lane |
| rd_valid_o | output | LANES | Read data valid per lane, one cycle after service |
| rd_data_o | output | LANES x 64 | Read data per lane, zero when not valid |
| stall_o | output | 1 | Some pending access could not be served this cycle |
| bank_en_o | output | 8 | Per-bank access enable for clock gating |

## Verification
The assertions check four things on every cycle. A read of register 0 returns zero. A valid flag follows a request from the previous cycle. Banks stay disabled when no lane makes a request. Stall never rises when every access targets the low region, or when fewer than two lanes read and fewer than two lanes write.

Other behaviour can only be shown by the bench's scenarios. These are the order in which conflicting lanes are served, the number of stall cycles, which write survives a collision, the old-value result of a read that meets a write, and the exact set of enabled banks. The bench covers them with sweeps over all 128 registers and with targeted conflict patterns.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int unsigned RF_NREG  = 128;
    localparam int unsigned RF_DW    = 64;
    localparam int unsigned RF_LANES = 4;
    localparam int unsigned RF_NBANK = 8;
    localparam int unsigned RF_LOWN  = 32;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int unsigned DW   = 64,
    parameter int unsigned ROWS = 16,
    localparam int unsigned RW  = $clog2(ROWS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          re_i,
    input  logic [RW-1:0] raddr_i,
    input  logic          we_i,
    input  logic [RW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [ROWS];
    logic [DW-1:0] rdata_d, rdata_q;

    // behavioural 1R1W macro: the read sees the contents before this edge's write
    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    always_comb rdata_d = re_i ? mem_q[raddr_i] : rdata_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/rf_lowregs.sv
module rf_lowregs #(
    parameter int unsigned DW    = 64,
    parameter int unsigned LOWN  = 32,
    parameter int unsigned LANES = 4,
    localparam int unsigned LAW  = $clog2(LOWN)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [LANES-1:0]           we_i,
    input  logic [LANES-1:0][LAW-1:0]  waddr_i,
    input  logic [LANES-1:0][DW-1:0]   wdata_i,
    input  logic [LANES-1:0][LAW-1:0]  raddr_i,
    output logic [LANES-1:0][DW-1:0]   rdata_o
);
    logic [LOWN-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        // ascending order: the highest lane's write lands last
        for (int l = 0; l < LANES; l++) begin
            if (we_i[l] && waddr_i[l] != '0) mem_d[waddr_i[l]] = wdata_i[l];
        end
        for (int l = 0; l < LANES; l++) begin
            rdata_o[l] = (raddr_i[l] == '0) ? '0 : mem_q[raddr_i[l]];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) mem_q <= '0;
        else         mem_q <= mem_d;
    end
endmodule

// File: rtl/rf_arbiter.sv
module rf_arbiter #(
    parameter int unsigned AW    = 7,
    parameter int unsigned LANES = 4,
    parameter int unsigned NBANK = 8,
    parameter int unsigned LOWN  = 32,
    localparam int unsigned BW   = $clog2(NBANK),
    localparam int unsigned LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0]          rd_pend_i,
    input  logic [LANES-1:0][AW-1:0]  rd_addr_i,
    input  logic [LANES-1:0]          wr_pend_i,
    input  logic [LANES-1:0][AW-1:0]  wr_addr_i,
    output logic [LANES-1:0]          rd_grant_o,
    output logic [LANES-1:0]          wr_grant_o,
    output logic [NBANK-1:0]          brd_en_o,
    output logic [NBANK-1:0][LW-1:0]  brd_lane_o,
    output logic [NBANK-1:0]          bwr_en_o,
    output logic [NBANK-1:0][LW-1:0]  bwr_lane_o
);
    always_comb begin
        rd_grant_o = '0;
        wr_grant_o = '0;
        brd_en_o   = '0;
        brd_lane_o = '0;
        bwr_en_o   = '0;
        bwr_lane_o = '0;
        for (int l = 0; l < LANES; l++) begin
            if (rd_pend_i[l] && rd_addr_i[l] < AW'(LOWN)) rd_grant_o[l] = 1'b1;
            if (wr_pend_i[l] && wr_addr_i[l] < AW'(LOWN)) wr_grant_o[l] = 1'b1;
        end
        for (int b = 0; b < NBANK; b++) begin
            for (int l = 0; l < LANES; l++) begin
                if (!brd_en_o[b] && rd_pend_i[l] && rd_addr_i[l] >= AW'(LOWN)
                    && rd_addr_i[l][BW-1:0] == BW'(b)) begin
                    brd_en_o[b]   = 1'b1;
                    brd_lane_o[b] = LW'(l);
                    rd_grant_o[l] = 1'b1;
                end
                if (!bwr_en_o[b] && wr_pend_i[l] && wr_addr_i[l] >= AW'(LOWN)
                    && wr_addr_i[l][BW-1:0] == BW'(b)) begin
                    bwr_en_o[b]   = 1'b1;
                    bwr_lane_o[b] = LW'(l);
                    wr_grant_o[l] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/banked_rf.sv
module banked_rf
    import rf_pkg::*;
#(
    parameter int unsigned NREG  = RF_NREG,
    parameter int unsigned DW    = RF_DW,
    parameter int unsigned LANES = RF_LANES,
    parameter int unsigned NBANK = RF_NBANK,
    parameter int unsigned LOWN  = RF_LOWN,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [LANES-1:0]          rd_req_i,
    input  logic [LANES-1:0][AW-1:0]  rd_addr_i,
    input  logic [LANES-1:0]          wr_req_i,
    input  logic [LANES-1:0][AW-1:0]  wr_addr_i,
    input  logic [LANES-1:0][DW-1:0]  wr_data_i,
    output logic [LANES-1:0]          rd_valid_o,
    output logic [LANES-1:0][DW-1:0]  rd_data_o,
    output logic                      stall_o,
    output logic [NBANK-1:0]          bank_en_o
);
    localparam int unsigned BW   = $clog2(NBANK);
    localparam int unsigned LW   = $clog2(LANES);
    localparam int unsigned LAW  = $clog2(LOWN);
    localparam int unsigned ROWS = NREG / NBANK;
    localparam int unsigned RW   = $clog2(ROWS);

    typedef struct packed {
        logic [LANES-1:0]         rd_served;
        logic [LANES-1:0]         wr_served;
        logic [LANES-1:0]         rd_valid;
        logic [LANES-1:0]         rd_low;
        logic [LANES-1:0][BW-1:0] rd_bank;
        logic [LANES-1:0][DW-1:0] low_data;
    } state_t;

    state_t d, q;

    logic [LANES-1:0]          rd_pend, wr_pend, rd_grant, wr_grant;
    logic [NBANK-1:0]          brd_en, bwr_en;
    logic [NBANK-1:0][LW-1:0]  brd_lane, bwr_lane;
    logic [NBANK-1:0][RW-1:0]  bk_raddr, bk_waddr;
    logic [NBANK-1:0][DW-1:0]  bk_wdata, bk_rdata;
    logic [LANES-1:0]          low_we;
    logic [LANES-1:0][LAW-1:0] low_waddr, low_raddr;
    logic [LANES-1:0][DW-1:0]  low_rdata;
    logic                      stall;

    rf_arbiter #(.AW(AW), .LANES(LANES), .NBANK(NBANK), .LOWN(LOWN)) arb_i (
        .rd_pend_i (rd_pend),  .rd_addr_i (rd_addr_i),
        .wr_pend_i (wr_pend),  .wr_addr_i (wr_addr_i),
        .rd_grant_o(rd_grant), .wr_grant_o(wr_grant),
        .brd_en_o  (brd_en),   .brd_lane_o(brd_lane),
        .bwr_en_o  (bwr_en),   .bwr_lane_o(bwr_lane)
    );

    rf_lowregs #(.DW(DW), .LOWN(LOWN), .LANES(LANES)) low_i (
        .clk_i  (clk_i),     .rst_ni (rst_ni),
        .we_i   (low_we),    .waddr_i(low_waddr), .wdata_i(wr_data_i),
        .raddr_i(low_raddr), .rdata_o(low_rdata)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rf_bank #(.DW(DW), .ROWS(ROWS)) bank_i (
            .clk_i  (clk_i),       .rst_ni (rst_ni),
            .re_i   (brd_en[b]),   .raddr_i(bk_raddr[b]),
            .we_i   (bwr_en[b]),   .waddr_i(bk_waddr[b]),
            .wdata_i(bk_wdata[b]), .rdata_o(bk_rdata[b])
        );
    end

    always_comb begin
        rd_pend = rd_req_i & ~q.rd_served;
        wr_pend = wr_req_i & ~q.wr_served;
        stall   = |(rd_pend & ~rd_grant) | |(wr_pend & ~wr_grant);

        for (int b = 0; b < NBANK; b++) begin
            bk_raddr[b] = rd_addr_i[brd_lane[b]][AW-1:BW];
            bk_waddr[b] = wr_addr_i[bwr_lane[b]][AW-1:BW];
            bk_wdata[b] = wr_data_i[bwr_lane[b]];
        end
        for (int l = 0; l < LANES; l++) begin
            low_we[l]    = wr_grant[l] && (wr_addr_i[l] < AW'(LOWN));
            low_waddr[l] = wr_addr_i[l][LAW-1:0];
            low_raddr[l] = rd_addr_i[l][LAW-1:0];
        end

        d           = q;
        d.rd_served = stall ? (q.rd_served | rd_grant) : '0;
        d.wr_served = stall ? (q.wr_served | wr_grant) : '0;
        d.rd_valid  = rd_grant;
        for (int l = 0; l < LANES; l++) begin
            if (rd_grant[l]) begin
                d.rd_low[l]   = rd_addr_i[l] < AW'(LOWN);
                d.rd_bank[l]  = rd_addr_i[l][BW-1:0];
                d.low_data[l] = low_rdata[l];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if (!q.rd_valid[l])  rd_data_o[l] = '0;
            else if (q.rd_low[l]) rd_data_o[l] = q.low_data[l];
            else                  rd_data_o[l] = bk_rdata[q.rd_bank[l]];
        end
    end

    assign rd_valid_o = q.rd_valid;
    assign stall_o    = stall;
    assign bank_en_o  = brd_en | bwr_en;
endmodule

// File: rtl/banked_rf_chk.sv
module banked_rf_chk #(
    parameter int unsigned AW    = 7,
    parameter int unsigned DW    = 64,
    parameter int unsigned LANES = 4,
    parameter int unsigned NBANK = 8,
    parameter int unsigned LOWN  = 32
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [LANES-1:0]          rd_req_i,
    input logic [LANES-1:0][AW-1:0]  rd_addr_i,
    input logic [LANES-1:0]          wr_req_i,
    input logic [LANES-1:0][AW-1:0]  wr_addr_i,
    input logic [LANES-1:0]          rd_valid_o,
    input logic [LANES-1:0][DW-1:0]  rd_data_o,
    input logic                      stall_o,
    input logic [NBANK-1:0]          bank_en_o
);
    logic all_low;
    always_comb begin
        all_low = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (rd_req_i[l] && rd_addr_i[l] >= AW'(LOWN)) all_low = 1'b0;
            if (wr_req_i[l] && wr_addr_i[l] >= AW'(LOWN)) all_low = 1'b0;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // R2
        a_r2_zero_reg_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_valid_o[l] && $past(rd_addr_i[l]) == '0) |-> rd_data_o[l] == '0);
        // R7
        a_r7_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rd_valid_o[l] |-> $past(rd_req_i[l]));
    end

    // R10
    a_r10_idle_banks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_i == '0 && wr_req_i == '0) |-> bank_en_o == '0);
    // R4
    a_r4_stall_needs_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> ($countones(rd_req_i) >= 2 || $countones(wr_req_i) >= 2));
    // R1
    a_r1_low_never_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
        all_low |-> !stall_o);
endmodule

bind banked_rf banked_rf_chk #(
    .AW(AW), .DW(DW), .LANES(LANES), .NBANK(NBANK), .LOWN(LOWN)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
    .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .stall_o(stall_o), .bank_en_o(bank_en_o)
);

// File: tb/banked_rf_tb_top.sv
module banked_rf_tb_top;
    localparam int L = 4;
    localparam int W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [L-1:0]        rd_req, wr_req, rd_valid;
    logic [L-1:0][6:0]   rd_addr, wr_addr;
    logic [L-1:0][W-1:0] wr_data, rd_data;
    logic                stall;
    logic [7:0]          bank_en;

    banked_rf dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .rd_req_i(rd_req), .rd_addr_i(rd_addr),
        .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .stall_o(stall), .bank_en_o(bank_en)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [W-1:0] mdl [128];
    logic [W-1:0] exp_rd [L];
    logic [W-1:0] got_data [L];
    int           got_cyc [L];
    int           n_cyc;
    int           n_stall;
    logic [7:0]   en_first;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int r, input int salt);
        return (64'h9E37_79B9_7F4A_7C15 * 64'(r + 1)) ^ (64'(salt) << 40);
    endfunction

    task automatic clear();
        rd_req = '0; wr_req = '0; rd_addr = '0; wr_addr = '0; wr_data = '0;
    endtask

    // called right after a falling edge with the inputs set
    task automatic run();
        bit st;
        for (int l = 0; l < L; l++) begin
            got_cyc[l] = -1;
            got_data[l] = '0;
            exp_rd[l] = (rd_addr[l] == 0) ? '0 : mdl[rd_addr[l]];
        end
        n_cyc = 0; n_stall = 0;
        #1;
        en_first = bank_en;
        do begin
            #1;
            st = stall;
            if (st) n_stall++;
            @(posedge clk);
            @(negedge clk);
            for (int l = 0; l < L; l++) begin
                if (rd_valid[l]) begin
                    got_cyc[l] = n_cyc;
                    got_data[l] = rd_data[l];
                end
            end
            n_cyc++;
        end while (st && n_cyc < 16);
        for (int l = 0; l < L; l++) begin
            if (wr_req[l] && wr_addr[l] != 0) mdl[wr_addr[l]] = wr_data[l];
        end
        clear();
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear();
        for (int r = 0; r < 128; r++) mdl[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk(stall == 0, "R11", "stall after reset", 64'(stall), 0);
        chk(rd_valid == 0, "R11", "valid after reset", 64'(rd_valid), 0);
        chk(bank_en == 0, "R11", "bank_en after reset", 64'(bank_en), 0);
        for (int r = 0; r < 32; r += 4) begin
            rd_req = '1;
            for (int l = 0; l < L; l++) rd_addr[l] = 7'(r + l);
            run();
            for (int l = 0; l < L; l++)
                chk(got_data[l] == 0 && got_cyc[l] == 0, "R11", "low reg zero after reset",
                    got_data[l], 0);
        end

        // R3 R1 R2: write sweep, four lanes per cycle, no conflicts
        for (int r = 0; r < 128; r += 4) begin
            wr_req = '1;
            for (int l = 0; l < L; l++) begin
                wr_addr[l] = 7'(r + l);
                wr_data[l] = pat(r + l, 1);
            end
            run();
            chk(n_stall == 0, (r < 32) ? "R1" : "R3", "write sweep stall", 64'(n_stall), 0);
            chk(en_first == ((r < 32) ? 8'h00 : (8'h0F << (r % 8))), "R10",
                "write sweep bank_en", 64'(en_first), 64'((r < 32) ? 8'h00 : (8'h0F << (r % 8))));
        end

        // R7 R2 R3: read sweep, data one cycle later
        for (int r = 0; r < 128; r += 4) begin
            rd_req = '1;
            for (int l = 0; l < L; l++) rd_addr[l] = 7'(r + l);
            run();
            chk(n_stall == 0, "R3", "read sweep stall", 64'(n_stall), 0);
            for (int l = 0; l < L; l++) begin
                chk(got_cyc[l] == 0, "R7", "read latency", 64'(got_cyc[l]), 0);
                chk(got_data[l] == exp_rd[l], (r + l == 0) ? "R2" : "R3", "read sweep data",
                    got_data[l], exp_rd[l]);
            end
        end

        // R1: four reads and four writes to the low region together
        rd_req = '1; wr_req = '1;
        for (int l = 0; l < L; l++) begin
            rd_addr[l] = 7'(8 + l); wr_addr[l] = 7'(20 + l); wr_data[l] = pat(l, 2);
        end
        run();
        chk(n_cyc == 1, "R1", "low 4R4W cycles", 64'(n_cyc), 1);
        for (int l = 0; l < L; l++)
            chk(got_data[l] == exp_rd[l], "R1", "low 4R4W data", got_data[l], exp_rd[l]);

        // R4: all lanes read bank 0, then pairs sharing banks
        rd_req = '1;
        for (int l = 0; l < L; l++) rd_addr[l] = 7'(32 + 8 * l);
        run();
        chk(n_stall == 3, "R4", "stall cycles four-way", 64'(n_stall), 3);
        chk(en_first == 8'h01, "R10", "bank_en first cycle", 64'(en_first), 1);
        for (int l = 0; l < L; l++) begin
            chk(got_cyc[l] == l, "R4", "lane service order", 64'(got_cyc[l]), 64'(l));
            chk(got_data[l] == exp_rd[l], "R4", "serialized read data", got_data[l], exp_rd[l]);
        end
        rd_req = '1;
        rd_addr[0] = 7'd37; rd_addr[1] = 7'd50; rd_addr[2] = 7'd45; rd_addr[3] = 7'd58;
        run();
        chk(n_stall == 1, "R4", "stall cycles two pairs", 64'(n_stall), 1);
        chk(got_cyc[0] == 0 && got_cyc[1] == 0 && got_cyc[2] == 1 && got_cyc[3] == 1, "R4",
            "pair order", 64'({got_cyc[3][3:0], got_cyc[2][3:0], got_cyc[1][3:0], got_cyc[0][3:0]}),
            64'h1100);
        for (int l = 0; l < L; l++)
            chk(got_data[l] == exp_rd[l], "R4", "pair data", got_data[l], exp_rd[l]);

        // R5: write conflicts in one bank, including the same register twice
        wr_req = '1;
        for (int l = 0; l < L; l++) begin wr_addr[l] = 7'(33 + 8 * l); wr_data[l] = pat(l, 3); end
        run();
        chk(n_stall == 3, "R5", "write stall cycles", 64'(n_stall), 3);
        wr_req = 4'b1010;
        wr_addr[1] = 7'd41; wr_data[1] = pat(7, 4);
        wr_addr[3] = 7'd41; wr_data[3] = pat(9, 4);
        run();
        chk(n_stall == 1, "R5", "same-reg write stall", 64'(n_stall), 1);
        rd_req = '1;
        for (int l = 0; l < L; l++) rd_addr[l] = 7'(33 + 8 * l);
        run();
        chk(got_data[1] == pat(9, 4), "R5", "higher lane write survives", got_data[1], pat(9, 4));
        for (int l = 0; l < L; l++)
            chk(got_data[l] == exp_rd[l], "R5", "written bank data", got_data[l], exp_rd[l]);

        // R6 R9: read and write of the same banked register in one cycle
        rd_req = 4'b0001; rd_addr[0] = 7'd34;
        wr_req = 4'b0010; wr_addr[1] = 7'd34; wr_data[1] = pat(34, 5);
        run();
        chk(n_stall == 0, "R6", "bank read+write no stall", 64'(n_stall), 0);
        chk(en_first == 8'h04, "R10", "bank_en read+write", 64'(en_first), 4);
        chk(got_data[0] == exp_rd[0], "R9", "banked read returns old", got_data[0], exp_rd[0]);
        rd_req = 4'b0001; rd_addr[0] = 7'd34;
        run();
        chk(got_data[0] == pat(34, 5), "R6", "banked write landed", got_data[0], pat(34, 5));

        // R8 R9: all lanes write reg 5 while lane 0 reads it
        rd_req = 4'b0001; rd_addr[0] = 7'd5;
        wr_req = '1;
        for (int l = 0; l < L; l++) begin wr_addr[l] = 7'd5; wr_data[l] = pat(l, 6); end
        run();
        chk(got_data[0] == exp_rd[0], "R9", "low read returns old", got_data[0], exp_rd[0]);
        rd_req = 4'b0001; rd_addr[0] = 7'd5;
        run();
        chk(got_data[0] == pat(3, 6), "R8", "highest lane wins", got_data[0], pat(3, 6));

        // R2: write to register 0 is dropped
        wr_req = 4'b0100; wr_addr[2] = 7'd0; wr_data[2] = '1;
        run();
        rd_req = 4'b1000; rd_addr[3] = 7'd0;
        run();
        chk(got_data[3] == 0 && got_cyc[3] == 0, "R2", "reg0 after write", got_data[3], 0);

        // R10: idle cycle
        #1;
        chk(bank_en == 0, "R10", "idle bank_en", 64'(bank_en), 0);
        @(posedge clk); @(negedge clk);
        chk(rd_valid == 0, "R7", "no valid without request", 64'(rd_valid), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule